// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block is a master-only, half-duplex serial shifter. It moves 8-bit frames over one shared open-drain data pad and drives a separate shift clock in both directions. A frame has no start or stop bits. Its bits go least significant first, and each bit lasts twelve system clock cycles.

Software writes a byte to start a transmit. A receive starts by itself while the receive enable is high and the receive flag is clear. Each direction has a completion flag that stays set until its clear input is pulsed. An interrupt output reports either flag when interrupts are enabled.

The controller has four states:
- `ST_IDLE`: the clock rests high and the pad is released.
- `ST_TX`: a byte is shifted out.
- `ST_RX`: a byte is shifted in.
- `ST_RX_END`: a one-cycle state that stores the received byte and raises the receive flag.

The transitions are:
- IDLE→TX on a write.
- IDLE→RX when the enable is high and the receive flag is clear, with no write in that cycle.
- TX→IDLE at the end of the eighth bit.
- RX→RX_END at the end of the eighth bit.
- RX_END→IDLE always.

Top module: `sync_shift_port`

## Requirements
- R1: After reset `shift_clk` is 1, `pad_pull_low` is 0, `tx_done`, `rx_done` and `irq` are 0, and `rx_data` is 0.
- R2: A `wr_en` pulse in idle starts a transmit. Bit k of the byte (k = 0 first) is presented for cycles 12k to 12k+11 after the write edge. `pad_pull_low` is 1 for a 0 bit and 0 for a 1 bit. The pad only starts pulling low while `shift_clk` is low.
- R3: In each bit time `shift_clk` is 0 for cycles 0–5 and 1 for cycles 6–11. When no transfer runs, it is 1.
- R4: A frame is exactly 8 bits. `tx_done` first reads 1 in cycle 96 after the write edge, when the port is idle again.
- R5: A receive starts when `rx_enable` is 1, `rx_done` is 0 and there is no write. The pad stays released throughout. The pad is sampled at each rising edge of `shift_clk`, and the first sample is bit 0.
- R6: `rx_data` and `rx_done` update one cycle after the eighth bit time ends. Both first read the new values in cycle 97 after the start edge.
- R7: While `rx_done` is 1, no receive starts, even with `rx_enable` high.
- R8: Each flag stays set until its clear input (`tx_flag_clr`, `rx_flag_clr`) is pulsed. A flag reads 0 the cycle after its clear.
- R9: A write during an active transmit or receive is ignored. The bits on the pad and the received byte are unchanged, and no transmit follows.
- R10: If a write and a receive start are valid in the same cycle, the transmit is taken.
- R11: `irq` is 1 exactly when `int_enable` is 1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe, starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rx_enable | input | 1 | Allows receives to start |
| int_enable | input | 1 | Enables the interrupt output |
| tx_flag_clr | input | 1 | Clears the transmit-complete flag |
| rx_flag_clr | input | 1 | Clears the receive-complete flag |
| pad_in | input | 1 | Sampled level of the data pad |
| pad_pull_low | output | 1 | Drives the data pad low when 1 |
| shift_clk | output | 1 | Shift clock to the peer |
| rx_data | output | 8 | Last received byte |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong phase count shows up within one bit time, as a shift clock whose low run is not six cycles or as a pad edge during the high phase. A wrong bit count shows up at cycle 96 or 97 of a frame, as a flag that rises early or late. A state that ignores priority or gating shows up in the first cycle after the stimulus. There it appears as a pad pull during a receive, or as a clock that starts while the receive flag is set.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TX     = 2'd1,
        ST_RX     = 2'd2,
        ST_RX_END = 2'd3
    } ssp_state_e;
endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic pre_rise,
    output logic bit_end
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || bit_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        phase_hi = (cnt >= CW'(HALF));
        pre_rise = run && (cnt == CW'(HALF - 1));
        bit_end  = run && (cnt == CW'(DIV - 1));
    end
endmodule

// File: rtl/ssp_bit_count.sv
module ssp_bit_count #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output logic last
);
    localparam int BW = $clog2(BITS);

    logic [BW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == BW'(BITS - 1));
endmodule

// File: rtl/ssp_shreg.sv
module ssp_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         fill,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {fill, q[W-1:1]};
        end
    end
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DATA_W = 8,
    parameter int DIV    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_enable,
    input  logic              int_enable,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  logic              pad_in,
    output logic              pad_pull_low,
    output logic              shift_clk,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_done,
    output logic              rx_done,
    output logic              irq
);
    import ssp_pkg::*;

    ssp_state_e        state, state_nx;
    logic              timer_run, phase_hi, pre_rise, bit_end;
    logic              last_bit, frame_end;
    logic              ld_tx, sh_tx, sh_rx;
    logic [DATA_W-1:0] sr_q;
    logic              set_tx, set_rx;

    assign timer_run = (state == ST_TX) || (state == ST_RX);
    assign frame_end = bit_end && last_bit;

    ssp_bit_timer #(.DIV(DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .phase_hi (phase_hi),
        .pre_rise (pre_rise),
        .bit_end  (bit_end)
    );

    ssp_bit_count #(.BITS(DATA_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!timer_run),
        .adv   (bit_end),
        .last  (last_bit)
    );

    ssp_shreg #(.W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_tx),
        .load_val (wr_data),
        .shift    (sh_tx || sh_rx),
        .fill     (sh_rx ? pad_in : 1'b1),
        .q        (sr_q)
    );

    ssp_flag u_tx_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_tx),
        .clr   (tx_flag_clr),
        .q     (tx_done)
    );

    ssp_flag u_rx_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_rx),
        .clr   (rx_flag_clr),
        .q     (rx_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and control strobes
    always_comb begin
        state_nx = state;
        ld_tx    = 1'b0;
        sh_tx    = 1'b0;
        sh_rx    = 1'b0;
        set_tx   = 1'b0;
        set_rx   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    state_nx = ST_TX;
                    ld_tx    = 1'b1;
                end else if (rx_enable && !rx_done) begin
                    state_nx = ST_RX;
                end
            end
            ST_TX: begin
                sh_tx = bit_end;
                if (frame_end) begin
                    state_nx = ST_IDLE;
                    set_tx   = 1'b1;
                end
            end
            ST_RX: begin
                sh_rx = pre_rise;
                if (frame_end) begin
                    state_nx = ST_RX_END;
                end
            end
            ST_RX_END: begin
                set_rx   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // received byte register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (state == ST_RX_END) begin
            rx_data <= sr_q;
        end
    end

    // pin outputs
    always_comb begin
        unique case (state)
            ST_TX: begin
                shift_clk    = phase_hi;
                pad_pull_low = !sr_q[0];
            end
            ST_RX: begin
                shift_clk    = phase_hi;
                pad_pull_low = 1'b0;
            end
            default: begin
                shift_clk    = 1'b1;
                pad_pull_low = 1'b0;
            end
        endcase
        irq = int_enable && (tx_done || rx_done);
    end
endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic int_enable,
    input logic tx_flag_clr,
    input logic rx_flag_clr,
    input logic pad_pull_low,
    input logic shift_clk,
    input logic tx_done,
    input logic rx_done,
    input logic irq
);
    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!shift_clk) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    AST_LOW_PHASE_SIX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> low_run == 8'd6); // R3
    AST_PULL_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_pull_low) |-> !shift_clk); // R2
    AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> shift_clk && !pad_pull_low); // R4
    AST_RX_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> !pad_pull_low); // R5
    AST_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !tx_flag_clr |=> tx_done); // R8
    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_flag_clr |=> rx_done); // R8
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && $past(rx_done) && !wr_en && $past(!wr_en) && shift_clk |=> shift_clk || tx_done == $past(tx_done)); // R7
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        int_enable && (tx_done || rx_done) |-> irq); // R11
endmodule

bind sync_shift_port sync_shift_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .int_enable   (int_enable),
    .tx_flag_clr  (tx_flag_clr),
    .rx_flag_clr  (rx_flag_clr),
    .pad_pull_low (pad_pull_low),
    .shift_clk    (shift_clk),
    .tx_done      (tx_done),
    .rx_done      (rx_done),
    .irq          (irq)
);

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_enable = 1'b0;
    logic       int_enable = 1'b0;
    logic       tx_flag_clr = 1'b0;
    logic       rx_flag_clr = 1'b0;
    logic       pad_drv = 1'b1;
    logic       pad_in;
    logic       pad_pull_low, shift_clk, tx_done, rx_done, irq;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;

    assign pad_in = pad_pull_low ? 1'b0 : pad_drv;

    always #2.5 clk = !clk;

    sync_shift_port uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rx_enable    (rx_enable),
        .int_enable   (int_enable),
        .tx_flag_clr  (tx_flag_clr),
        .rx_flag_clr  (rx_flag_clr),
        .pad_in       (pad_in),
        .pad_pull_low (pad_pull_low),
        .shift_clk    (shift_clk),
        .rx_data      (rx_data),
        .tx_done      (tx_done),
        .rx_done      (rx_done),
        .irq          (irq)
    );

    function automatic logic exp_clk(int i);
        return (i % 12) >= 6;
    endfunction

    function automatic logic exp_pull(logic [7:0] b, int i);
        return !b[i / 12];
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_irq(string req);
        chk(irq == (int_enable && (tx_done || rx_done)), req, irq, int_enable && (tx_done || rx_done));
    endtask

    // transmit; optional simultaneous rx_enable and an extra write mid-frame
    task automatic do_tx(logic [7:0] b, logic with_rx, logic [7:0] late_b, logic late_wr);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b; rx_enable = with_rx;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 96; i++) begin
            chk(shift_clk == exp_clk(i), "R3 clk", shift_clk, exp_clk(i));
            chk(pad_pull_low == exp_pull(b, i), with_rx ? "R10 pad" : (late_wr ? "R9 pad" : "R2 pad"),
                pad_pull_low, exp_pull(b, i));
            if (i == 95) begin
                chk(tx_done == 1'b0, "R4 early", tx_done, 0);
                rx_enable = 1'b0;
            end
            if (late_wr && i == 30) begin wr_en = 1'b1; wr_data = late_b; end
            if (i == 31) wr_en = 1'b0;
            @(negedge clk);
        end
        chk(tx_done == 1'b1, "R4 done", tx_done, 1);
        chk(shift_clk == 1'b1 && pad_pull_low == 1'b0, "R3 idle", {shift_clk, pad_pull_low}, 2);
        chk_irq("R11 tx");
        repeat (3) @(negedge clk);
        chk(shift_clk == 1'b1 && pad_pull_low == 1'b0, "R9 no follow-up", {shift_clk, pad_pull_low}, 2);
    endtask

    task automatic do_rx(logic [7:0] b, logic late_wr, logic hold_en);
        logic tx_before;
        tx_before = tx_done;
        @(negedge clk);
        rx_enable = 1'b1; pad_drv = b[0];
        @(negedge clk);
        for (int i = 0; i < 97; i++) begin
            if (i < 96) begin
                if (i % 12 == 0) pad_drv = b[i / 12];
                chk(shift_clk == exp_clk(i), "R5 clk", shift_clk, exp_clk(i));
            end
            chk(pad_pull_low == 1'b0, late_wr ? "R9 rx pad" : "R5 pad", pad_pull_low, 0);
            if (i == 96) chk(rx_done == 1'b0, "R6 early", rx_done, 0);
            if (late_wr && i == 40) begin wr_en = 1'b1; wr_data = ~b; end
            if (i == 41) wr_en = 1'b0;
            if (i == 94 && !hold_en) rx_enable = 1'b0;
            @(negedge clk);
        end
        pad_drv = 1'b1;
        chk(rx_done == 1'b1, "R6 flag", rx_done, 1);
        chk(rx_data == b, late_wr ? "R9 data" : "R6 data", rx_data, b);
        chk(tx_done == tx_before, "R9 no tx", tx_done, tx_before);
        chk_irq("R11 rx");
        if (hold_en) begin
            for (int i = 0; i < 30; i++) begin
                chk(shift_clk == 1'b1, "R7 blocked", shift_clk, 1);
                @(negedge clk);
            end
            rx_enable = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clr_flags();
        @(negedge clk);
        tx_flag_clr = 1'b1; rx_flag_clr = 1'b1;
        @(negedge clk);
        tx_flag_clr = 1'b0; rx_flag_clr = 1'b0;
        chk(tx_done == 1'b0 && rx_done == 1'b0, "R8 clear", {tx_done, rx_done}, 0);
        chk_irq("R11 clear");
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(shift_clk == 1'b1 && pad_pull_low == 1'b0, "R1 pins", {shift_clk, pad_pull_low}, 2);
        chk(tx_done == 1'b0 && rx_done == 1'b0 && irq == 1'b0, "R1 flags", {tx_done, rx_done, irq}, 0);
        chk(rx_data == 8'h00, "R1 data", rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        int_enable = 1'b1;
        do_tx(8'h00, 1'b0, 8'h00, 1'b0);
        repeat (20) @(negedge clk);
        chk(tx_done == 1'b1, "R8 sticky", tx_done, 1);
        clr_flags();
        do_tx(8'hA5, 1'b0, 8'h5A, 1'b1);
        clr_flags();
        do_tx(8'h3C, 1'b1, 8'h00, 1'b0);
        clr_flags();
        do_rx(8'hFF, 1'b0, 1'b1);
        clr_flags();
        do_rx(8'h96, 1'b1, 1'b0);
        int_enable = 1'b0;
        @(negedge clk);
        chk_irq("R11 masked");
        clr_flags();

        // random mix
        for (int n = 0; n < 24; n++) begin
            logic [7:0] b;
            b = 8'($urandom);
            int_enable = 1'($urandom);
            if ($urandom % 2 == 0) do_tx(b, 1'b0, 8'h00, 1'($urandom));
            else do_rx(b, 1'($urandom), 1'b0);
            clr_flags();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule